// File: doc/BRIEF.md
# Deep-Sleep Exit Ramp Sequencer

This block runs the wake-up from the deepest processor sleep state. While the processor sleeps it holds two regulator control outputs in the sleep encoding. When a wake-up ("break") request arrives from the upstream event classifier, it switches those outputs to request a voltage ramp. It then times the ramp with a programmable down-counter and raises a one-cycle completion pulse when the ramp is over.

Break requests come in two classes. A slow break is a request that may recur at a periodic timer-tick rate. When the slow-exit enable is set, a slow break selects a gentle ramp first: the regulator keeps its low-power indication for an extra programmable number of cycles before the normal ramp timer starts. A fast break always selects the normal ramp at once. A fast break that arrives during the extra wait cuts the wait short on the next clock edge. All controls are plain level pins sampled on the clock; there is no streamed data and no handshake.

Top module: `c4x_exit_seq`

## Requirements
- R1: After reset the block is in the sleep state: `deep_stop_n_o`=0, `vr_lowpwr_o`=1, `exit_done_o`=0.
- R2: With `slow_en_i`=1 and `slow_dly_i`=N>0, a lone slow break seen in the sleep state gives N cycles of the slow-ramp encoding (`deep_stop_n_o`=1, `vr_lowpwr_o`=1), starting in the cycle after the edge that samples the break.
- R3: The normal ramp encoding (`deep_stop_n_o`=1, `vr_lowpwr_o`=0) lasts `ramp_len_i` cycles, and the block then enters the completed state.
- R4: A fast break seen in the sleep state starts the normal ramp in the next cycle, with no slow wait.
- R5: A fast break during the slow wait drops `vr_lowpwr_o` in the next cycle and starts the full normal ramp from there.
- R6: Fast and slow breaks sampled on the same edge take the fast flow.
- R7: With `slow_en_i`=0, a slow break is handled exactly like a fast break.
- R8: A delay or ramp length of 0 skips that phase, so the next phase (or the completed state) follows directly.
- R9: `exit_done_o` is high for exactly one cycle, the first cycle of the completed state. The outputs keep the normal ramp encoding until a new sleep entry.
- R10: Breaks seen during the ramp or in the completed state have no effect. `c4_enter_i` sampled in the completed state returns the block to the sleep encoding in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c4_enter_i | input | 1 | Request to re-enter the sleep state (honoured once the exit is complete) |
| brk_slow_i | input | 1 | Slow-class break request |
| brk_fast_i | input | 1 | Fast-class break request |
| slow_en_i | input | 1 | Enables the slow-exit wait for slow breaks |
| slow_dly_i | input | 8 | Extra wait length in cycles for slow breaks |
| ramp_len_i | input | 8 | Normal ramp timer length in cycles |
| deep_stop_n_o | output | 1 | Active-low deeper-stop request to the regulator |
| vr_lowpwr_o | output | 1 | Regulator low-power indication; high in the sleep state and during the slow wait |
| exit_done_o | output | 1 | One-cycle pulse when the ramp timer expires |

## Verification
Several properties are checked on every cycle: the single-cycle width of the completion pulse, the cut-short of the slow wait by a fast break, the fast-over-slow priority and the disabled-enable case, the return to sleep on entry requests, and that neither timer runs past zero. Only the bench scenarios can show the exact cycle counts of each phase for given delay and ramp values. The same holds for skipping a phase at a value of 0, and for breaks being ignored while the ramp runs; the bench's scoreboard shows these by comparing every output cycle against a predicted trace.

// File: rtl/c4x_pkg.sv
package c4x_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP = 2'd0,
    ST_SLOW  = 2'd1,
    ST_RAMP  = 2'd2,
    ST_DONE  = 2'd3
  } c4x_state_e;

  typedef struct packed {
    logic deep_stop_n;
    logic vr_lowpwr;
  } c4x_vr_t;

  function automatic c4x_vr_t c4x_encode(c4x_state_e st);
    c4x_vr_t v;
    case (st)
      ST_SLEEP: begin v.deep_stop_n = 1'b0; v.vr_lowpwr = 1'b1; end
      ST_SLOW:  begin v.deep_stop_n = 1'b1; v.vr_lowpwr = 1'b1; end
      default:  begin v.deep_stop_n = 1'b1; v.vr_lowpwr = 1'b0; end
    endcase
    return v;
  endfunction
endpackage

// File: rtl/c4x_tmr.sv
module c4x_tmr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         run_i,
  output logic         last_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - ONE;
  end

  assign last_o = (cnt_q == ONE);

  AST_TMR_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i) |-> (cnt_q != '0)); // R8
endmodule

// File: rtl/c4x_ctrl.sv
module c4x_ctrl
  import c4x_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         c4_enter_i,
  input  logic         brk_slow_i,
  input  logic         brk_fast_i,
  input  logic         slow_en_i,
  input  logic [W-1:0] slow_dly_i,
  input  logic [W-1:0] ramp_len_i,
  input  logic         dly_last_i,
  input  logic         ramp_last_i,
  output logic         ld_dly_o,
  output logic         ld_ramp_o,
  output c4x_state_e   state_o,
  output logic         done_o
);
  c4x_state_e st_q, st_d;
  logic       done_q;
  logic       go_fast;
  logic       begin_ramp;

  // slow break falls back to the fast flow when disabled or with zero delay
  assign go_fast = brk_fast_i |
                   (brk_slow_i & ~slow_en_i) |
                   (brk_slow_i & (slow_dly_i == '0));

  always_comb begin
    st_d       = st_q;
    ld_dly_o   = 1'b0;
    begin_ramp = 1'b0;
    case (st_q)
      ST_SLEEP: begin
        if (go_fast) begin
          begin_ramp = 1'b1;
        end else if (brk_slow_i) begin
          st_d     = ST_SLOW;
          ld_dly_o = 1'b1;
        end
      end
      ST_SLOW: begin
        if (brk_fast_i || dly_last_i) begin_ramp = 1'b1;
      end
      ST_RAMP: begin
        if (ramp_last_i) st_d = ST_DONE;
      end
      default: begin
        if (c4_enter_i) st_d = ST_SLEEP;
      end
    endcase
    if (begin_ramp) st_d = (ramp_len_i == '0) ? ST_DONE : ST_RAMP;
  end

  assign ld_ramp_o = begin_ramp && (ramp_len_i != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SLEEP;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_d == ST_DONE) && (st_q != ST_DONE);
    end
  end

  assign state_o = st_q;
  assign done_o  = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
  AST_FAST_CUTS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLOW && brk_fast_i) |=> (st_q == ST_RAMP || st_q == ST_DONE)); // R5
  AST_FAST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLEEP && brk_fast_i) |=> (st_q != ST_SLOW)); // R6
  AST_DISABLED_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLEEP && !slow_en_i) |=> (st_q != ST_SLOW)); // R7
  AST_REENTER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE && c4_enter_i) |=> (st_q == ST_SLEEP)); // R10
  AST_RAMP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RAMP && !ramp_last_i) |=> (st_q == ST_RAMP)); // R3
endmodule

// File: rtl/c4x_exit_seq.sv
module c4x_exit_seq
  import c4x_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             c4_enter_i,
  input  logic             brk_slow_i,
  input  logic             brk_fast_i,
  input  logic             slow_en_i,
  input  logic [CNT_W-1:0] slow_dly_i,
  input  logic [CNT_W-1:0] ramp_len_i,
  output logic             deep_stop_n_o,
  output logic             vr_lowpwr_o,
  output logic             exit_done_o
);
  c4x_state_e st;
  c4x_vr_t    vr;
  logic       ld_dly, ld_ramp, dly_last, ramp_last;

  c4x_ctrl #(.W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .c4_enter_i  (c4_enter_i),
    .brk_slow_i  (brk_slow_i),
    .brk_fast_i  (brk_fast_i),
    .slow_en_i   (slow_en_i),
    .slow_dly_i  (slow_dly_i),
    .ramp_len_i  (ramp_len_i),
    .dly_last_i  (dly_last),
    .ramp_last_i (ramp_last),
    .ld_dly_o    (ld_dly),
    .ld_ramp_o   (ld_ramp),
    .state_o     (st),
    .done_o      (exit_done_o)
  );

  c4x_tmr #(.W(CNT_W)) u_dly_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ld_dly),
    .load_val_i (slow_dly_i),
    .run_i      (st == ST_SLOW),
    .last_o     (dly_last)
  );

  c4x_tmr #(.W(CNT_W)) u_ramp_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ld_ramp),
    .load_val_i (ramp_len_i),
    .run_i      (st == ST_RAMP),
    .last_o     (ramp_last)
  );

  assign vr            = c4x_encode(st);
  assign deep_stop_n_o = vr.deep_stop_n;
  assign vr_lowpwr_o   = vr.vr_lowpwr;

  AST_LOWPWR_NEEDS_STOP_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vr_lowpwr_o) |-> !deep_stop_n_o); // R10
endmodule

// File: tb/test_c4x_exit_seq.sv
module test_c4x_exit_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       c4_enter_i = 1'b0, brk_slow_i = 1'b0, brk_fast_i = 1'b0, slow_en_i = 1'b0;
  logic [7:0] slow_dly_i = '0, ramp_len_i = '0;
  logic       deep_stop_n_o, vr_lowpwr_o, exit_done_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic  ds;
    logic  vr;
    logic  dn;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  c4x_exit_seq i_c4x_exit_seq (
    .clk(clk), .rst_n(rst_n), .c4_enter_i(c4_enter_i),
    .brk_slow_i(brk_slow_i), .brk_fast_i(brk_fast_i), .slow_en_i(slow_en_i),
    .slow_dly_i(slow_dly_i), .ramp_len_i(ramp_len_i),
    .deep_stop_n_o(deep_stop_n_o), .vr_lowpwr_o(vr_lowpwr_o), .exit_done_o(exit_done_o)
  );

  task automatic cmp(input logic ds, input logic vr, input logic dn, input string tag);
    checks++;
    if ({deep_stop_n_o, vr_lowpwr_o, exit_done_o} !== {ds, vr, dn}) begin
      errors++;
      $display("FAIL %s: got ds_n=%b vr=%b done=%b, expected ds_n=%b vr=%b done=%b",
               tag, deep_stop_n_o, vr_lowpwr_o, exit_done_o, ds, vr, dn);
    end
  endtask

  // monitor: one expected item per cycle, sampled 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        cmp(e.ds, e.vr, e.dn, e.tag);
      end
    end
  end

  task automatic push(input logic ds, input logic vr, input logic dn, input string tag);
    exp_t e;
    e.ds = ds; e.vr = vr; e.dn = dn; e.tag = tag;
    sb.push_back(e);
  endtask

  // fk: cycles after the break at which a fast break is injected (0 = none)
  task automatic run(input logic slow, input logic fast, input logic en,
                     input int dly, input int len, input int fk,
                     input string tw, input string tr);
    int w;
    int total;
    logic fast_flow;
    fast_flow = fast || (slow && !en) || (slow && dly == 0);
    w = fast_flow ? 0 : dly;
    if (!fast_flow && fk > 0 && fk < dly) w = fk;
    @(negedge clk);
    brk_slow_i = slow; brk_fast_i = fast; slow_en_i = en;
    slow_dly_i = 8'(dly); ramp_len_i = 8'(len);
    for (int i = 0; i < w; i++)   push(1'b1, 1'b1, 1'b0, tw);
    for (int i = 0; i < len; i++) push(1'b1, 1'b0, 1'b0, tr);
    push(1'b1, 1'b0, 1'b1, "R9");
    push(1'b1, 1'b0, 1'b0, "R9");
    push(1'b1, 1'b0, 1'b0, "R10");
    total = w + len + 3;
    for (int i = 1; i <= total; i++) begin
      @(negedge clk);
      if (i == 1) begin brk_slow_i = 1'b0; brk_fast_i = 1'b0; end
      if (fk > 0 && i == fk) brk_fast_i = 1'b1;
      if (fk > 0 && i == fk + 1) brk_fast_i = 1'b0;
      if (i == total - 1) brk_slow_i = 1'b1;   // ignored in completed state
      if (i == total) brk_slow_i = 1'b0;
    end
    c4_enter_i = 1'b1;
    push(1'b0, 1'b1, 1'b0, "R10");
    @(negedge clk);
    c4_enter_i = 1'b0;
    while (sb.size() > 0) @(negedge clk);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    cmp(1'b0, 1'b1, 1'b0, "R1");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp(1'b0, 1'b1, 1'b0, "R1");
    run(1'b1, 1'b0, 1'b1, 3, 2, 0, "R2", "R3");   // slow exit
    run(1'b0, 1'b1, 1'b1, 0, 4, 0, "R4", "R4");   // fast exit
    run(1'b1, 1'b1, 1'b1, 5, 2, 0, "R6", "R6");   // both at once
    run(1'b1, 1'b0, 1'b0, 5, 3, 0, "R7", "R7");   // slow, disabled
    run(1'b1, 1'b0, 1'b1, 6, 3, 2, "R5", "R5");   // fast cuts wait
    run(1'b1, 1'b0, 1'b1, 6, 2, 1, "R5", "R5");   // cut after one cycle
    run(1'b1, 1'b0, 1'b1, 0, 2, 0, "R8", "R8");   // zero delay
    run(1'b0, 1'b1, 1'b1, 0, 0, 0, "R8", "R8");   // zero ramp
    run(1'b1, 1'b0, 1'b1, 2, 0, 0, "R8", "R8");   // wait then no ramp
    run(1'b1, 1'b0, 1'b1, 2, 4, 3, "R10", "R10"); // fast during ramp ignored
    run(1'b1, 1'b0, 1'b1, 1, 1, 0, "R2", "R3");   // minimal lengths
    cmp(1'b0, 1'b1, 1'b0, "R10");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule